// File: doc/BRIEF.md
# Temperature-Monitor Sequencer

This block runs an external temperature-sensor converter without software involvement. When automatic mode is on, it waits a programmable number of clock cycles and then scans the enabled sensor slots, lowest index first. For each slot it issues a one-cycle start request and waits for the converter's done strobe, then stores the 12-bit result. The converter's code falls as the die heats, so a slot is "over" a limit when its code is at or below that limit.

Every stored sample is compared with two limits for its slot: an alarm limit and a shutdown limit. Each comparison has its own run-length counter, and an event fires only after a programmed number of consecutive over-limit samples. Alarm events set per-slot pending bits, which feed a maskable interrupt. Shutdown events latch per-slot and drive two shutdown outputs, one toward the reset controller and one toward a general-purpose pin. Each slot is routed to either output or both, and the active level is selectable. While any enabled slot reads over its alarm limit, a shorter wait period replaces the normal one. Software reaches all of this through a flat word-addressed register port.

Top module: `tmon_sequencer`

## Requirements
- R1: After reset the normal period (0x68) reads 1000, the hot period (0x6C) reads 100, both debounce counts (alarm 0x60, shutdown 0x64) read 10, control (0x04) and pending (0x0C) read 0, `irq` is 0, `adcStart` is 0, and both shutdown outputs are 1, which is the inactive level while the polarity bit is 0.
- R2: The alarm limit of slot i is at 0x30+4i and the shutdown limit at 0x40+4i. These, the periods, the debounce counts, control and interrupt enable (0x08) read back what was written. The data registers at 0x20+4i are read-only, and writes to them have no effect.
- R3: While control bit 0 is set, each scan converts every slot whose source-enable bit (control bit 4+i) is set, in ascending index order. Each conversion is one single-cycle `adcStart` with `adcChan` held until `adcDone`, and the result is stored in that slot's data register.
- R4: The first `adcStart` of the next scan is high exactly P+1 cycles after the cycle in which the scan's last `adcDone` is high. P is the period in effect.
- R5: P equals the hot period while any source-enabled slot's latest sample is at or below its alarm limit. Otherwise P equals the normal period.
- R6: Pending bit i (0x0C bit i) sets on the sample that brings slot i's count of consecutive samples at or below its alarm limit up to the alarm debounce count. A sample above the limit clears the count.
- R7: `irq` is high exactly while some pending bit i has its enable bit i set in 0x08. Pending bits are recorded even when the enable bit is clear.
- R8: A write to 0x0C with bit 8 low clears each pending bit written as 1. A write with bit 8 high changes nothing.
- R9: Slot i's shutdown latch sets on the sample that brings its run of samples at or below the shutdown limit up to the shutdown debounce count. The latch stays set until reset, even after later samples read cool.
- R10: `shutGpio` is active when a latched slot has 0x08 bit 4+i set, and `shutRst` is active when a latched slot has 0x08 bit 8+i set. Control bit 8 set makes the active level 1; clear makes it 0.
- R11: Clearing control bit 0 stops new conversions. Setting it again resumes scanning with the programmed limits intact.
- R12: A data register reads 0 until its slot's first conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| adcStart | output | 1 | One-cycle conversion request |
| adcChan | output | 2 | Slot being converted |
| adcDone | input | 1 | Converter result valid |
| adcData | input | 12 | Converter result code |
| irq | output | 1 | Alarm interrupt |
| shutGpio | output | 1 | Shutdown toward the general-purpose pin |
| shutRst | output | 1 | Shutdown toward the reset controller |

## Verification
The properties assume the converter raises `adcDone` once and only once per `adcStart`, never before that start, and for a single cycle. They also assume that register writes and the converter share the block clock. The bench's converter model answers each start with a single done pulse two cycles later and carries the code set for the requested slot. Limits and debounce counts are changed only between scans, so no sample is compared against a half-written setting.

// File: rtl/tmon_pkg.sv
`timescale 1ns/1ps
package tmon_pkg;
  localparam int SLOT_W = 2;

  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_IEN  = 8'h08;
  localparam logic [7:0] OFS_PEND = 8'h0C;
  localparam logic [7:0] OFS_DATA = 8'h20;
  localparam logic [7:0] OFS_ALM  = 8'h30;
  localparam logic [7:0] OFS_SHT  = 8'h40;
  localparam logic [7:0] OFS_ADB  = 8'h60;
  localparam logic [7:0] OFS_SDB  = 8'h64;
  localparam logic [7:0] OFS_PER  = 8'h68;
  localparam logic [7:0] OFS_HPER = 8'h6C;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} seqState_t;

  typedef struct packed {
    logic              capture;
    logic [SLOT_W-1:0] chan;
  } seqStrobe_t;
endpackage

// File: rtl/tmon_chan_slot.sv
`timescale 1ns/1ps
module tmon_chan_slot #(
  parameter int DATA_W = 12,
  parameter int DB_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrAlm,
  input  logic              wrSht,
  input  logic [DATA_W-1:0] wrVal,
  input  logic              capture,
  input  logic [DATA_W-1:0] sample,
  input  logic [DB_W-1:0]   almDb,
  input  logic [DB_W-1:0]   shtDb,
  output logic [DATA_W-1:0] dataVal,
  output logic [DATA_W-1:0] almThr,
  output logic [DATA_W-1:0] shtThr,
  output logic              overAlm,
  output logic              almEvent,
  output logic              shutOn
);
  localparam logic [DB_W-1:0] CNT_MAX = '1;

  logic [DB_W-1:0] almCntQ, almCntD, shtCntQ, shtCntD;
  logic sampleAlm, sampleSht, shtEvent;

  // lower code means hotter
  assign sampleAlm = (sample <= almThr);
  assign sampleSht = (sample <= shtThr);

  always_comb begin
    almCntD = sampleAlm ? ((almCntQ == CNT_MAX) ? almCntQ : almCntQ + 1'b1) : '0;
    shtCntD = sampleSht ? ((shtCntQ == CNT_MAX) ? shtCntQ : shtCntQ + 1'b1) : '0;
    almEvent = capture && sampleAlm && (almDb != '0)
               && (almCntD == almDb) && (almCntQ != almDb);
    shtEvent = capture && sampleSht && (shtDb != '0)
               && (shtCntD == shtDb) && (shtCntQ != shtDb);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataVal <= '0;
      almThr  <= '0;
      shtThr  <= '0;
      overAlm <= 1'b0;
      almCntQ <= '0;
      shtCntQ <= '0;
      shutOn  <= 1'b0;
    end else begin
      if (wrAlm) almThr <= wrVal;
      if (wrSht) shtThr <= wrVal;
      if (capture) begin
        dataVal <= sample;
        overAlm <= sampleAlm;
        almCntQ <= almCntD;
        shtCntQ <= shtCntD;
      end
      if (shtEvent) shutOn <= 1'b1;
    end
  end
endmodule

// File: rtl/tmon_datapath.sv
`timescale 1ns/1ps
module tmon_datapath
  import tmon_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int PER_W  = 16,
  parameter int DB_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [DATA_W-1:0] adcData,
  input  seqStrobe_t        strobe,
  output logic              autoEn,
  output logic [NUM_CH-1:0] srcEn,
  output logic [PER_W-1:0]  curPeriod,
  output logic              irq,
  output logic              shutGpio,
  output logic              shutRst,
  output logic [NUM_CH-1:0] pendBits,
  output logic [NUM_CH-1:0] shutBits
);
  localparam logic [PER_W-1:0] PER_RST  = PER_W'(1000);
  localparam logic [PER_W-1:0] HPER_RST = PER_W'(100);
  localparam logic [DB_W-1:0]  DB_RST   = DB_W'(10);

  logic              polHighQ;
  logic [NUM_CH-1:0] almIenQ, gpioRouteQ, rstRouteQ, pendQ, pendClr;
  logic [NUM_CH-1:0] almEvents, overAlmV;
  logic [DB_W-1:0]   almDbQ, shtDbQ;
  logic [PER_W-1:0]  perQ, hotPerQ;
  logic [NUM_CH-1:0][DATA_W-1:0] dataArr, almArr, shtArr;
  logic              unusedHi;

  assign unusedHi = ^regWdata[31:16];

  function automatic logic hit(input logic [7:0] a);
    return regWr && (regAddr == a);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoEn     <= 1'b0;
      srcEn      <= '0;
      polHighQ   <= 1'b0;
      almIenQ    <= '0;
      gpioRouteQ <= '0;
      rstRouteQ  <= '0;
      almDbQ     <= DB_RST;
      shtDbQ     <= DB_RST;
      perQ       <= PER_RST;
      hotPerQ    <= HPER_RST;
    end else begin
      if (hit(OFS_CTRL)) begin
        autoEn   <= regWdata[0];
        srcEn    <= regWdata[4 +: NUM_CH];
        polHighQ <= regWdata[8];
      end
      if (hit(OFS_IEN)) begin
        almIenQ    <= regWdata[0 +: NUM_CH];
        gpioRouteQ <= regWdata[4 +: NUM_CH];
        rstRouteQ  <= regWdata[8 +: NUM_CH];
      end
      if (hit(OFS_ADB))  almDbQ  <= regWdata[DB_W-1:0];
      if (hit(OFS_SDB))  shtDbQ  <= regWdata[DB_W-1:0];
      if (hit(OFS_PER))  perQ    <= regWdata[PER_W-1:0];
      if (hit(OFS_HPER)) hotPerQ <= regWdata[PER_W-1:0];
    end
  end

  // write-back with bit 8 low clears the ones written; new events win
  assign pendClr = (hit(OFS_PEND) && !regWdata[8]) ? regWdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~pendClr) | almEvents;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    tmon_chan_slot #(.DATA_W(DATA_W), .DB_W(DB_W)) u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .wrAlm    (hit(OFS_ALM + 8'(4*g))),
      .wrSht    (hit(OFS_SHT + 8'(4*g))),
      .wrVal    (regWdata[DATA_W-1:0]),
      .capture  (strobe.capture && (strobe.chan == SLOT_W'(g))),
      .sample   (adcData),
      .almDb    (almDbQ),
      .shtDb    (shtDbQ),
      .dataVal  (dataArr[g]),
      .almThr   (almArr[g]),
      .shtThr   (shtArr[g]),
      .overAlm  (overAlmV[g]),
      .almEvent (almEvents[g]),
      .shutOn   (shutBits[g])
    );
  end

  assign curPeriod = (|(overAlmV & srcEn)) ? hotPerQ : perQ;
  assign irq       = |(pendQ & almIenQ);
  assign shutGpio  = polHighQ ? (|(shutBits & gpioRouteQ)) : ~(|(shutBits & gpioRouteQ));
  assign shutRst   = polHighQ ? (|(shutBits & rstRouteQ))  : ~(|(shutBits & rstRouteQ));
  assign pendBits  = pendQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CTRL: begin
        regRdata[0]            = autoEn;
        regRdata[4 +: NUM_CH]  = srcEn;
        regRdata[8]            = polHighQ;
      end
      OFS_IEN: begin
        regRdata[0 +: NUM_CH]  = almIenQ;
        regRdata[4 +: NUM_CH]  = gpioRouteQ;
        regRdata[8 +: NUM_CH]  = rstRouteQ;
      end
      OFS_PEND: regRdata[NUM_CH-1:0] = pendQ;
      OFS_ADB:  regRdata[DB_W-1:0]   = almDbQ;
      OFS_SDB:  regRdata[DB_W-1:0]   = shtDbQ;
      OFS_PER:  regRdata[PER_W-1:0]  = perQ;
      OFS_HPER: regRdata[PER_W-1:0]  = hotPerQ;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == OFS_DATA + 8'(4*i)) regRdata[DATA_W-1:0] = dataArr[i];
      if (regAddr == OFS_ALM  + 8'(4*i)) regRdata[DATA_W-1:0] = almArr[i];
      if (regAddr == OFS_SHT  + 8'(4*i)) regRdata[DATA_W-1:0] = shtArr[i];
    end
  end
endmodule

// File: rtl/tmon_ctrl.sv
`timescale 1ns/1ps
module tmon_ctrl
  import tmon_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoEn,
  input  logic [NUM_CH-1:0] srcEn,
  input  logic [PER_W-1:0]  curPeriod,
  input  logic              adcDone,
  output logic              adcStart,
  output logic [SLOT_W-1:0] adcChan,
  output seqStrobe_t        strobe,
  output logic              seqIdle
);
  seqState_t         state;
  logic [SLOT_W-1:0] chanQ, firstIdx, nextIdx;
  logic              haveFirst, haveNext;
  logic [PER_W-1:0]  waitCnt;
  logic [PER_W:0]    cntInc;

  assign cntInc = {1'b0, waitCnt} + 1'b1;

  // lowest enabled slot overall and above the current one
  always_comb begin
    haveFirst = 1'b0;
    firstIdx  = '0;
    haveNext  = 1'b0;
    nextIdx   = '0;
    for (int i = NUM_CH-1; i >= 0; i--) begin
      if (srcEn[i]) begin
        haveFirst = 1'b1;
        firstIdx  = SLOT_W'(i);
      end
      if (srcEn[i] && (i > int'(chanQ))) begin
        haveNext = 1'b1;
        nextIdx  = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      chanQ   <= '0;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!autoEn) begin
            waitCnt <= '0;
          end else if (cntInc >= {1'b0, curPeriod}) begin
            waitCnt <= '0;
            if (haveFirst) begin
              chanQ <= firstIdx;
              state <= ST_START;
            end
          end else begin
            waitCnt <= cntInc[PER_W-1:0];
          end
        end
        ST_START: state <= ST_WAIT;
        ST_WAIT: begin
          if (adcDone) begin
            if (autoEn && haveNext) begin
              chanQ <= nextIdx;
              state <= ST_START;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adcStart       = (state == ST_START);
  assign adcChan        = chanQ;
  assign strobe.capture = (state == ST_WAIT) && adcDone;
  assign strobe.chan    = chanQ;
  assign seqIdle        = (state == ST_IDLE);
endmodule

// File: rtl/tmon_sequencer.sv
`timescale 1ns/1ps
module tmon_sequencer
  import tmon_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int PER_W  = 16,
  parameter int DB_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              adcStart,
  output logic [SLOT_W-1:0] adcChan,
  input  logic              adcDone,
  input  logic [DATA_W-1:0] adcData,
  output logic              irq,
  output logic              shutGpio,
  output logic              shutRst
);
  seqStrobe_t        strobe;
  logic              autoEn, seqIdle;
  logic [NUM_CH-1:0] srcEn, pendBits, shutBits;
  logic [PER_W-1:0]  curPeriod;

  tmon_ctrl #(.NUM_CH(NUM_CH), .PER_W(PER_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .autoEn    (autoEn),
    .srcEn     (srcEn),
    .curPeriod (curPeriod),
    .adcDone   (adcDone),
    .adcStart  (adcStart),
    .adcChan   (adcChan),
    .strobe    (strobe),
    .seqIdle   (seqIdle)
  );

  tmon_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .PER_W(PER_W), .DB_W(DB_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .adcData   (adcData),
    .strobe    (strobe),
    .autoEn    (autoEn),
    .srcEn     (srcEn),
    .curPeriod (curPeriod),
    .irq       (irq),
    .shutGpio  (shutGpio),
    .shutRst   (shutRst),
    .pendBits  (pendBits),
    .shutBits  (shutBits)
  );
endmodule

// File: rtl/tmon_checker.sv
`timescale 1ns/1ps
module tmon_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              adcStart,
  input logic [1:0]        adcChan,
  input logic              autoEn,
  input logic              seqIdle,
  input logic              capture,
  input logic [NUM_CH-1:0] pendBits,
  input logic [NUM_CH-1:0] shutBits
);
  // R3: each start request lasts one cycle
  p_single_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R3: slot index holds while the conversion is outstanding
  p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> $stable(adcChan));

  // R11: idle with automatic mode off issues no start
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (seqIdle && !autoEn) |=> !adcStart);

  // R6: a pending bit only rises right after a stored sample
  p_alarm_on_sample_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((pendBits & ~$past(pendBits)) != '0) |-> $past(capture));

  // R9: a shutdown latch only sets right after a stored sample
  p_shut_on_sample_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((shutBits & ~$past(shutBits)) != '0) |-> $past(capture));

  // R9: a set shutdown latch never clears
  p_shut_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((~shutBits & $past(shutBits)) == '0));
endmodule

bind tmon_sequencer tmon_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .adcStart (adcStart),
  .adcChan  (adcChan),
  .autoEn   (autoEn),
  .seqIdle  (seqIdle),
  .capture  (strobe.capture),
  .pendBits (pendBits),
  .shutBits (shutBits)
);

// File: tb/tmon_sequencer_bench.sv
`timescale 1ns/1ps
module tmon_sequencer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        adcStart;
  logic [1:0]  adcChan;
  logic        adcDone = 1'b0;
  logic [11:0] adcData = '0;
  logic        irq, shutGpio, shutRst;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int startCount = 0;
  int lastStartCyc = 0;
  int lastDoneCyc = 0;
  int doneCount [4] = '{0, 0, 0, 0};
  logic [1:0]  startLog [256];
  logic [11:0] adcVal [4] = '{12'h800, 12'h800, 12'h800, 12'h800};
  logic [1:0]  adcCh = '0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  tmon_sequencer u_tmon_sequencer (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .adcStart(adcStart),
    .adcChan(adcChan), .adcDone(adcDone), .adcData(adcData),
    .irq(irq), .shutGpio(shutGpio), .shutRst(shutRst));

  always @(posedge clk) cyc <= cyc + 1;

  // converter model: result two cycles after each start
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && adcStart) begin
        adcCh = adcChan;
        repeat (2) @(posedge clk);
        #1 adcDone = 1'b1; adcData = adcVal[adcCh];
        @(posedge clk);
        #1 adcDone = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && adcStart) begin
      startLog[startCount & 255] = adcChan;
      startCount = startCount + 1;
      lastStartCyc = cyc;
    end
    if (rstN && adcDone) begin
      doneCount[adcCh] = doneCount[adcCh] + 1;
      lastDoneCyc = cyc;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1 regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1 regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1 regAddr = a;
    @(negedge clk); d = regRdata;
  endtask

  task automatic wait_ch2(input int n);
    int target;
    target = doneCount[2] + n;
    while (doneCount[2] < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure_gap(input string req, input int exp);
    int d;
    int s0;
    wait_ch2(1);
    d = lastDoneCyc;
    s0 = startCount;
    while (startCount == s0) @(negedge clk);
    chk(req, 32'(lastStartCyc - d), 32'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 start", {31'b0, adcStart}, 32'h0);
    chk("R1 shutGpio", {31'b0, shutGpio}, 32'h1);
    chk("R1 shutRst", {31'b0, shutRst}, 32'h1);
    rd(8'h68, rv); chk("R1 period", rv, 32'd1000);
    rd(8'h6C, rv); chk("R1 hot period", rv, 32'd100);
    rd(8'h60, rv); chk("R1 alarm debounce", rv, 32'd10);
    rd(8'h64, rv); chk("R1 shut debounce", rv, 32'd10);
    rd(8'h04, rv); chk("R1 control", rv, 32'h0);
    rd(8'h0C, rv); chk("R1 pending", rv, 32'h0);
  endtask

  task automatic t_scan;
    int s0;
    for (int i = 0; i < 4; i++) begin
      wr(8'(8'h30 + 4*i), 32'h100);
      wr(8'(8'h40 + 4*i), 32'h050);
    end
    wr(8'h60, 32'd3);
    wr(8'h64, 32'd2);
    wr(8'h68, 32'd20);
    wr(8'h6C, 32'd8);
    rd(8'h34, rv); chk("R2 alarm limit", rv, 32'h100);
    rd(8'h4C, rv); chk("R2 shutdown limit", rv, 32'h050);
    rd(8'h68, rv); chk("R2 period", rv, 32'd20);
    rd(8'h20, rv); chk("R12 data before conversion", rv, 32'h0);
    s0 = startCount;
    wr(8'h04, 32'h051);
    wait_ch2(1);
    chk("R3 starts per scan", 32'(startCount - s0), 32'd2);
    chk("R3 first slot", {30'b0, startLog[s0 & 255]}, 32'd0);
    chk("R3 second slot", {30'b0, startLog[(s0 + 1) & 255]}, 32'd2);
    rd(8'h20, rv); chk("R3 data slot0", rv, 32'h800);
    rd(8'h28, rv); chk("R3 data slot2", rv, 32'h800);
    rd(8'h24, rv); chk("R12 unconverted slot1", rv, 32'h0);
    wr(8'h24, 32'hABC);
    rd(8'h24, rv); chk("R2 data read-only", rv, 32'h0);
    measure_gap("R4 normal gap", 21);
  endtask

  task automatic t_hot;
    wait_ch2(1);
    adcVal[2] = 12'h0F0;
    wait_ch2(2);
    rd(8'h0C, rv); chk("R6 two samples not enough", rv, 32'h0);
    wait_ch2(1);
    rd(8'h0C, rv); chk("R6 third sample sets pending", rv, 32'h4);
    chk("R7 masked irq", {31'b0, irq}, 32'h0);
    measure_gap("R5 hot gap", 9);
    adcVal[0] = 12'h0F0;
    wait_ch2(2);
    adcVal[0] = 12'h800;
    wait_ch2(1);
    adcVal[0] = 12'h0F0;
    wait_ch2(2);
    rd(8'h0C, rv); chk("R6 cool sample restarts run", rv, 32'h4);
    wait_ch2(1);
    rd(8'h0C, rv); chk("R6 run completes", rv, 32'h5);
    adcVal[0] = 12'h800;
  endtask

  task automatic t_irq;
    wr(8'h08, 32'h004);
    @(negedge clk); chk("R7 enabled irq", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h105);
    rd(8'h0C, rv); chk("R8 bit8 set ignored", rv, 32'h5);
    wr(8'h0C, 32'h001);
    rd(8'h0C, rv); chk("R8 partial clear", rv, 32'h4);
    chk("R7 irq still from slot2", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h004);
    rd(8'h0C, rv); chk("R8 full clear", rv, 32'h0);
    chk("R7 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_shut;
    wr(8'h04, 32'h151);
    @(negedge clk);
    chk("R10 inactive high polarity gpio", {31'b0, shutGpio}, 32'h0);
    chk("R10 inactive high polarity rst", {31'b0, shutRst}, 32'h0);
    wr(8'h08, 32'h014);
    wait_ch2(1);
    adcVal[0] = 12'h040;
    wait_ch2(1);
    chk("R9 one sample not enough", {31'b0, shutGpio}, 32'h0);
    wait_ch2(1);
    chk("R9 shutdown latched to gpio", {31'b0, shutGpio}, 32'h1);
    chk("R10 reset path not routed", {31'b0, shutRst}, 32'h0);
    wr(8'h08, 32'h114);
    @(negedge clk); chk("R10 reset path routed", {31'b0, shutRst}, 32'h1);
    wr(8'h04, 32'h051);
    @(negedge clk);
    chk("R10 active low gpio", {31'b0, shutGpio}, 32'h0);
    chk("R10 active low rst", {31'b0, shutRst}, 32'h0);
    wr(8'h04, 32'h151);
    adcVal[0] = 12'h800;
    wait_ch2(2);
    chk("R9 stays latched when cool", {31'b0, shutGpio}, 32'h1);
  endtask

  task automatic t_pause;
    int s0;
    int waited;
    wait_ch2(1);
    wr(8'h04, 32'h150);
    repeat (6) @(negedge clk);
    s0 = startCount;
    repeat (100) @(negedge clk);
    chk("R11 no starts while off", 32'(startCount - s0), 32'd0);
    rd(8'h38, rv); chk("R11 limit kept", rv, 32'h100);
    wr(8'h04, 32'h151);
    waited = 0;
    while (startCount == s0 && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    chk("R11 resumes", {31'b0, startCount != s0}, 32'h1);
    wait_ch2(1);
    rd(8'h28, rv); chk("R11 fresh data after resume", rv, 32'h0F0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog act=timeout exp=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_scan();
    t_hot();
    t_irq();
    t_shut();
    t_pause();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule